// File: doc/BRIEF.md
# Supply Fault Supervisor with Sequenced Restart

This block watches three supply fault flags that arrive already synchronised to its clock: an over-temperature condition, given as a set flag and a separate clear flag, an input under-voltage level and an input over-voltage level. It drives a single power-good force-low line and one run-allow bit for each of four regulators. When a fault appears, it lowers power-good at once. If the fault is still present after a grace period, it turns every regulator off. Once all faults have cleared and any hold-off has run out, it allows the channels to run again one at a time, in a fixed order, with fixed spacing between them.

All time is counted in ticks of a 1 µs strobe input. Every duration is a parameter given in ticks: the grace before shutdown, the minimum power-good low time after a voltage fault, the thermal restart hold-off and the spacing between channel releases. A bench can therefore run the same logic with scaled-down timing. The block also brings out its current state so that its sequence can be observed.

Top module: `supply_fault_supervisor`

## Requirements
- R1: After reset, `sup_state` reads 0 (normal), `run_allow` has all bits set and `pg_force_low` is 0.
- R2: Any active fault while in state normal moves the block to state grace (1) on the next clock edge. In grace, `pg_force_low` is 1 and `run_allow` still has all bits set.
- R3: If a fault is still present when GRACE_TICKS ticks have elapsed in grace, the block enters state shutdown (2) and `run_allow` becomes all zero.
- R4: If every fault clears before the grace period ends, the block returns to normal with no shutdown. `run_allow` never drops. After the rising edge of a combined under/over-voltage fault, `pg_force_low` stays 1 until PG_HOLD_TICKS ticks have elapsed.
- R5: A pulse on `ot_set` latches the over-temperature fault, and only `ot_clr` removes it. When both are high in the same cycle, set wins. Once a shutdown caused by over-temperature clears, the block waits in state hold-off (3) for THERM_HOLD_TICKS ticks with `run_allow` all zero.
- R6: After a shutdown caused only by under-voltage or over-voltage, the block enters state sequencing (4) on the clock edge after the last fault clears, with no hold-off.
- R7: In sequencing, `run_allow` takes the values 0001, 0011, 0111 and then 1111, with bit 0 released first and each new bit following STEP_TICKS ticks after the previous one. When bit 3 is set, the state becomes normal.
- R8: After a voltage-fault shutdown, `pg_force_low` falls only when both conditions hold: the restart sequence has completed, and PG_HOLD_TICKS ticks have passed since the fault began.
- R9: A fault that appears during sequencing aborts it. On the next clock edge the state is shutdown and `run_allow` is all zero.
- R10: When several faults overlap, shutdown is held until all of them have cleared. If over-temperature was among them, the thermal hold-off still applies.
- R11: A fault during hold-off returns the block to shutdown. The full hold-off restarts after that fault clears.
- R12: An over-temperature event cleared within the grace period returns the block to normal with no hold-off, and `pg_force_low` drops one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1us | input | 1 | One-cycle time-base strobe, one per tick |
| ot_set | input | 1 | Over-temperature set flag |
| ot_clr | input | 1 | Over-temperature clear flag |
| uv_flag | input | 1 | Input under-voltage level |
| ov_flag | input | 1 | Input over-voltage level |
| pg_force_low | output | 1 | Forces every power-good output low |
| run_allow | output | N_CH | Per-regulator permission to run; bit 0 is released first |
| sup_state | output | 3 | 0 normal, 1 grace, 2 shutdown, 3 hold-off, 4 sequencing |

## Verification
The hardest situations to reach are faults that arrive in the middle of a recovery. One is a new fault during the staggered release, after some channels are already running. The other is a brief voltage dip during the long thermal hold-off, where the check must show that the hold-off restarted rather than continued. The stimulus reaches these by timing each fault from the moment the previous fault was cleared, placing it in the middle of a step or hold-off window. The bench then samples the outputs at points that separate "restarted" from "continued". Random pulse lengths are drawn from ranges kept clear of each threshold, so the outcome the bench expects does not depend on tick phase.

// File: rtl/supv_pkg.sv
package supv_pkg;
  typedef enum logic [2:0] {
    ST_NORM  = 3'd0,
    ST_GRACE = 3'd1,
    ST_OFF   = 3'd2,
    ST_WAIT  = 3'd3,
    ST_RAMP  = 3'd4
  } sup_state_e;

  function automatic int unsigned bits_for(input int unsigned v);
    return (v < 2) ? 1 : $clog2(v + 1);
  endfunction
endpackage

// File: rtl/sfs_therm_latch.sv
module sfs_therm_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic hot_o
);
  logic hot_q;

  // set has priority over clear
  assign hot_o = set_i | (hot_q & ~clr_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hot_q <= 1'b0;
    else        hot_q <= hot_o;
  end
endmodule

// File: rtl/sfs_tick_timer.sv
module sfs_tick_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         tick_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)                      cnt_d = load_val_i;
    else if (tick_i && cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done_o = (cnt_q == '0);

  AST_TMR_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && cnt_q == '0) |=> (cnt_q == '0)); // R3
endmodule

// File: rtl/sfs_stagger.sv
module sfs_stagger #(
  parameter int N_CH = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_i,
  input  logic            start_i,
  input  logic            step_i,
  output logic [N_CH-1:0] en_o,
  output logic            fill_o
);
  localparam logic [N_CH-1:0] ONE_CH = N_CH'(1);
  logic [N_CH-1:0] en_q, en_d;

  generate
    if (N_CH == 1) begin : g_single
      always_comb begin
        en_d = en_q;
        if (clr_i)        en_d = '0;
        else if (start_i) en_d = ONE_CH;
      end
      assign fill_o = 1'b1;
    end else begin : g_multi
      always_comb begin
        en_d = en_q;
        if (clr_i)        en_d = '0;
        else if (start_i) en_d = ONE_CH;
        else if (step_i)  en_d = {en_q[N_CH-2:0], 1'b1};
      end
      // next step sets the final channel
      assign fill_o = en_q[N_CH-2];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_d;
  end

  assign en_o = en_q;
endmodule

// File: rtl/supply_fault_supervisor.sv
module supply_fault_supervisor
  import supv_pkg::*;
#(
  parameter int N_CH             = 4,
  parameter int GRACE_TICKS      = 5000,
  parameter int PG_HOLD_TICKS    = 50000,
  parameter int THERM_HOLD_TICKS = 2000000,
  parameter int STEP_TICKS       = 500
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_1us,
  input  logic            ot_set,
  input  logic            ot_clr,
  input  logic            uv_flag,
  input  logic            ov_flag,
  output logic            pg_force_low,
  output logic [N_CH-1:0] run_allow,
  output logic [2:0]      sup_state
);
  localparam int TMW_A = bits_for(GRACE_TICKS);
  localparam int TMW_B = bits_for(THERM_HOLD_TICKS);
  localparam int TMW_C = bits_for(STEP_TICKS);
  localparam int TMW   = (TMW_A > TMW_B) ? ((TMW_A > TMW_C) ? TMW_A : TMW_C)
                                         : ((TMW_B > TMW_C) ? TMW_B : TMW_C);
  localparam int HDW   = bits_for(PG_HOLD_TICKS);
  localparam logic [TMW-1:0] GRACE_V = TMW'(GRACE_TICKS);
  localparam logic [TMW-1:0] THERM_V = TMW'(THERM_HOLD_TICKS);
  localparam logic [TMW-1:0] STEP_V  = TMW'(STEP_TICKS);
  localparam logic [HDW-1:0] HOLD_V  = HDW'(PG_HOLD_TICKS);
  localparam logic [N_CH-1:0] ONE_CH = N_CH'(1);

  sup_state_e st_q, st_d;
  logic hot, volt_bad, volt_bad_q, fault_any;
  logic therm_seen_q, therm_seen_d;
  logic tm_load, tm_done, hold_done;
  logic [TMW-1:0] tm_val;
  logic stg_clr, stg_start, stg_step, stg_fill;
  logic [N_CH-1:0] stg_en;

  sfs_therm_latch u_therm (
    .clk(clk), .rst_n(rst_n), .set_i(ot_set), .clr_i(ot_clr), .hot_o(hot)
  );

  assign volt_bad  = uv_flag | ov_flag;
  assign fault_any = hot | volt_bad;

  sfs_tick_timer #(.W(TMW)) u_phase_tmr (
    .clk(clk), .rst_n(rst_n), .load_i(tm_load), .load_val_i(tm_val),
    .tick_i(tick_1us), .done_o(tm_done)
  );

  // minimum power-good low window, armed on each new voltage fault
  sfs_tick_timer #(.W(HDW)) u_hold_tmr (
    .clk(clk), .rst_n(rst_n), .load_i(volt_bad & ~volt_bad_q), .load_val_i(HOLD_V),
    .tick_i(tick_1us), .done_o(hold_done)
  );

  sfs_stagger #(.N_CH(N_CH)) u_stagger (
    .clk(clk), .rst_n(rst_n), .clr_i(stg_clr), .start_i(stg_start),
    .step_i(stg_step), .en_o(stg_en), .fill_o(stg_fill)
  );

  always_comb begin
    st_d      = st_q;
    tm_load   = 1'b0;
    tm_val    = '0;
    stg_clr   = 1'b0;
    stg_start = 1'b0;
    stg_step  = 1'b0;
    case (st_q)
      ST_NORM: if (fault_any) begin
        st_d = ST_GRACE; tm_load = 1'b1; tm_val = GRACE_V;
      end
      ST_GRACE: begin
        if (!fault_any)   st_d = ST_NORM;
        else if (tm_done) begin st_d = ST_OFF; stg_clr = 1'b1; end
      end
      ST_OFF: begin
        stg_clr = 1'b1;
        if (!fault_any) begin
          if (therm_seen_q) begin
            st_d = ST_WAIT; tm_load = 1'b1; tm_val = THERM_V;
          end else begin
            st_d = ST_RAMP; tm_load = 1'b1; tm_val = STEP_V;
            stg_clr = 1'b0; stg_start = 1'b1;
          end
        end
      end
      ST_WAIT: begin
        if (fault_any) st_d = ST_OFF;
        else if (tm_done) begin
          st_d = ST_RAMP; tm_load = 1'b1; tm_val = STEP_V; stg_start = 1'b1;
        end
      end
      ST_RAMP: begin
        if (fault_any) begin st_d = ST_OFF; stg_clr = 1'b1; end
        else if (tm_done) begin
          stg_step = 1'b1;
          if (stg_fill) st_d = ST_NORM;
          else begin tm_load = 1'b1; tm_val = STEP_V; end
        end
      end
      default: st_d = ST_OFF;
    endcase
  end

  always_comb begin
    therm_seen_d = therm_seen_q;
    if (hot)                                   therm_seen_d = 1'b1;
    else if (st_d == ST_NORM || st_d == ST_RAMP) therm_seen_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q         <= ST_NORM;
      therm_seen_q <= 1'b0;
      volt_bad_q   <= 1'b0;
    end else begin
      st_q         <= st_d;
      therm_seen_q <= therm_seen_d;
      volt_bad_q   <= volt_bad;
    end
  end

  always_comb begin
    case (st_q)
      ST_NORM, ST_GRACE: run_allow = '1;
      ST_RAMP:           run_allow = stg_en;
      default:           run_allow = '0;
    endcase
  end

  assign pg_force_low = (st_q != ST_NORM) | ~hold_done;
  assign sup_state    = st_q;

  AST_GRACE_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_GRACE && !fault_any) |=> (st_q == ST_NORM)); // R4
  AST_WAIT_STAGGER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT) |-> (stg_en == '0)); // R5
  AST_OFF_NO_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_OFF) |=> (st_q == ST_OFF || st_q == ST_WAIT || st_q == ST_RAMP)); // R6
  AST_RAMP_THERMO: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RAMP) |-> (stg_en[0] && ((stg_en & (stg_en + ONE_CH)) == '0))); // R7
  AST_RAMP_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RAMP && fault_any) |=> (run_allow == '0)); // R9
  AST_THERM_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_OFF && !fault_any && therm_seen_q) |=> (st_q == ST_WAIT)); // R10
  AST_WAIT_REFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT && fault_any) |=> (st_q == ST_OFF)); // R11
endmodule

// File: tb/sim_supply_fault_supervisor.sv
module sim_supply_fault_supervisor;
  localparam int N_CH = 4;

  logic clk, rst_n, tick_1us, ot_set, ot_clr, uv_flag, ov_flag;
  logic pg_force_low;
  logic [N_CH-1:0] run_allow;
  logic [2:0] sup_state;
  int total, bad, tdiv;
  bit finished;

  supply_fault_supervisor #(
    .N_CH(N_CH), .GRACE_TICKS(20), .PG_HOLD_TICKS(200),
    .THERM_HOLD_TICKS(400), .STEP_TICKS(10)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .tick_1us(tick_1us), .ot_set(ot_set), .ot_clr(ot_clr),
    .uv_flag(uv_flag), .ov_flag(ov_flag), .pg_force_low(pg_force_low),
    .run_allow(run_allow), .sup_state(sup_state)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // one tick every four clocks
  always @(negedge clk) begin
    if (!rst_n) begin tdiv = 0; tick_1us = 1'b0; end
    else begin tdiv = (tdiv + 1) % 4; tick_1us = (tdiv == 0); end
  end

  function automatic logic [N_CH-1:0] thermo(input int n);
    return N_CH'((1 << n) - 1);
  endfunction

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_set(); ot_set = 1'b1; wt(1); ot_set = 1'b0; endtask
  task automatic pulse_clr(); ot_clr = 1'b1; wt(1); ot_clr = 1'b0; endtask
  task automatic volt(input bit which, input bit v);
    if (which) ov_flag = v; else uv_flag = v;
  endtask

  initial begin
    rst_n = 1'b0; ot_set = 0; ot_clr = 0; uv_flag = 0; ov_flag = 0;
    total = 0; bad = 0;
    void'($urandom(32'd4127));
    wt(3); rst_n = 1'b1; wt(2);
    chk("R1 state", 8'(sup_state), 8'd0);
    chk("R1 run", 8'(run_allow), 8'(thermo(4)));
    chk("R1 pg", 8'(pg_force_low), 8'd0);

    // short voltage dips: no shutdown, power-good held
    for (int i = 0; i < 3; i++) begin
      bit w = 1'($urandom_range(0, 1));
      int len = $urandom_range(5, 40);
      volt(w, 1'b1); wt(2);
      chk("R2 state", 8'(sup_state), 8'd1);
      chk("R2 pg", 8'(pg_force_low), 8'd1);
      chk("R2 run", 8'(run_allow), 8'(thermo(4)));
      wt(len - 2); volt(w, 1'b0); wt(3);
      chk("R4 state", 8'(sup_state), 8'd0);
      chk("R4 run", 8'(run_allow), 8'(thermo(4)));
      wt(700 - len - 3);
      chk("R4 pg held", 8'(pg_force_low), 8'd1);
      wt(200);
      chk("R4 pg freed", 8'(pg_force_low), 8'd0);
    end

    // longer voltage faults: shutdown and staggered restart
    for (int i = 0; i < 3; i++) begin
      bit w = 1'($urandom_range(0, 1));
      int len = $urandom_range(200, 500);
      volt(w, 1'b1); wt(120);
      chk("R3 state", 8'(sup_state), 8'd2);
      chk("R3 run", 8'(run_allow), 8'd0);
      wt(len - 120); volt(w, 1'b0); wt(2);
      chk("R6 state", 8'(sup_state), 8'd4);
      wt(18);  chk("R7 step1", 8'(run_allow), 8'(thermo(1)));
      wt(40);  chk("R7 step2", 8'(run_allow), 8'(thermo(2)));
      wt(40);  chk("R7 step3", 8'(run_allow), 8'(thermo(3)));
      wt(50);  chk("R7 done", 8'(sup_state), 8'd0);
      chk("R7 all", 8'(run_allow), 8'(thermo(4)));
      chk("R8 pg held", 8'(pg_force_low), 8'd1);
      wt(900 - len - 150);
      chk("R8 pg freed", 8'(pg_force_low), 8'd0);
    end

    // over-voltage beyond the hold window
    ov_flag = 1'b1; wt(1000); ov_flag = 1'b0; wt(150);
    chk("R8 long state", 8'(sup_state), 8'd0);
    chk("R8 long pg", 8'(pg_force_low), 8'd0);

    // thermal event with hold-off
    pulse_set(); wt(120);
    chk("R5 latched", 8'(sup_state), 8'd2);
    wt(180); pulse_clr(); wt(1);
    chk("R5 holdoff", 8'(sup_state), 8'd3);
    chk("R5 run", 8'(run_allow), 8'd0);
    wt(1000); chk("R5 still", 8'(sup_state), 8'd3);
    wt(619);
    chk("R5 ramp", 8'(sup_state), 8'd4);
    chk("R5 first", 8'(run_allow), 8'(thermo(1)));
    wt(200); chk("R5 done", 8'(sup_state), 8'd0);

    // set and clear together: set wins
    ot_set = 1'b1; ot_clr = 1'b1; wt(1); ot_set = 1'b0; ot_clr = 1'b0; wt(1);
    chk("R5 set wins", 8'(sup_state), 8'd1);
    wt(120); chk("R5 set wins off", 8'(sup_state), 8'd2);
    pulse_clr(); wt(1900);
    chk("R5 recover", 8'(sup_state), 8'd0);

    // thermal cleared inside grace
    pulse_set(); wt(20); pulse_clr(); wt(1);
    chk("R12 state", 8'(sup_state), 8'd0);
    chk("R12 pg", 8'(pg_force_low), 8'd0);
    chk("R12 run", 8'(run_allow), 8'(thermo(4)));

    // overlapping faults
    uv_flag = 1'b1; wt(2); pulse_set(); wt(150);
    chk("R10 off", 8'(sup_state), 8'd2);
    uv_flag = 1'b0; wt(20);
    chk("R10 still off", 8'(sup_state), 8'd2);
    pulse_clr(); wt(1);
    chk("R10 holdoff", 8'(sup_state), 8'd3);
    wt(1900); chk("R10 recover", 8'(sup_state), 8'd0);

    // abort during staggered restart
    wt(900);
    ov_flag = 1'b1; wt(300); ov_flag = 1'b0; wt(60);
    chk("R9 pre", 8'(run_allow), 8'(thermo(2)));
    uv_flag = 1'b1; wt(2);
    chk("R9 state", 8'(sup_state), 8'd2);
    chk("R9 run", 8'(run_allow), 8'd0);
    wt(10); uv_flag = 1'b0; wt(2);
    chk("R9 restart", 8'(run_allow), 8'(thermo(1)));
    wt(200); chk("R9 done", 8'(sup_state), 8'd0);

    // fault during thermal hold-off restarts it
    wt(900);
    pulse_set(); wt(150); pulse_clr(); wt(200);
    chk("R11 pre", 8'(sup_state), 8'd3);
    uv_flag = 1'b1; wt(2);
    chk("R11 off", 8'(sup_state), 8'd2);
    wt(10); uv_flag = 1'b0; wt(2);
    chk("R11 holdoff", 8'(sup_state), 8'd3);
    wt(1500); chk("R11 restarted", 8'(sup_state), 8'd3);
    wt(300); chk("R11 done", 8'(sup_state), 8'd0);

    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule